// File: doc/BRIEF.md
# DMA Channel Programming Register Bank

This block is the processor-side register file of a four-channel DMA controller of the classic personal-computer kind. A host reaches it over a narrow I/O bus: a four-bit port offset, a chip select, one-cycle read and write strobes, and byte-wide data in each direction. Each channel owns a sixteen-bit start address and a sixteen-bit transfer count. Every one of these is kept as a base copy and a current copy, and is reached one byte at a time. A single byte-pointer flag, shared by all channels, chooses the low or the high byte. Software returns the flag to the low byte with a dedicated write.

Beside the per-channel values, the bank keeps a six-bit mode field per channel, one mask bit per channel, a command byte and a status byte. The programmed base values, modes, masks and command are driven straight from registers to the transfer engine. The engine sends back one terminal-count pulse per channel. Those pulses are latched into status, and they mask any channel that is not set to reload itself. Status also shows the request lines, sampled through one register stage.

Top module: `dma_regbank`

## Requirements
- R1: While `rst` is high, and on the first edge after it, every mask bit is 1 and these all read as zero: command, status, byte pointer, `rdata`, every address, every count and every mode field.
- R2: A write to offset 2n loads a byte of channel n's address, and a write to offset 2n+1 loads a byte of its count (n = 0..3). The byte goes to both the base and the current copy. It is the low byte when the pointer is low and the high byte when it is high. `base_addr`/`base_count` slice n (bits 16n+15..16n) shows the change one clock after the write.
- R3: A read of offset 2n or 2n+1 returns the byte of the current address or count that the pointer selects. `rdata` is registered: it carries the value in the cycle after the read strobe, and it is 0x00 in any cycle that follows no read.
- R4: One byte pointer serves all eight address and count offsets. Each read or write at offsets 0x0–0x7 toggles it, whichever channel is addressed. A write to offset 0xC returns it to low, whatever the data.
- R5: A write to offset 0xA updates one mask bit. Data bits [1:0] select the channel, and data bit 2 is written as the new mask value (1 = masked).
- R6: A write to offset 0xB stores data bits [7:2] as the mode field of the channel that data bits [1:0] select, shown on `chan_mode` bits 6n+5..6n. For example, 0x46 gives channel 2 the field 0x11, and 0xC3 gives channel 3 the field 0x30. Field bit 2 (data bit 4) is the auto-initialize flag.
- R7: A write to offset 0xE clears all four mask bits. A write to offset 0xF loads the mask from data bits [3:0] and ignores bits [7:4].
- R8: A write to offset 0x8 loads the command byte onto `cmd_reg`.
- R9: A read of offset 0x8 returns status. Bits [3:0] are sticky terminal-count flags, one per channel. Bits [7:4] are `dreq` as registered on the edge before the read. The read clears the flags after returning them, but a pulse that arrives in the read cycle stays set and appears on the next read.
- R10: A `tc_pulse` bit for a channel whose auto-initialize flag is 0 sets that channel's mask bit on the next edge. When the flag is 1, the mask bit is left unchanged.
- R11: A write to offset 0xD, whatever the data, sets all mask bits and clears the command byte, the status flags and the byte pointer. Addresses, counts and modes keep their values. A read of 0xD returns 0x00.
- R12: A strobe with `cs` low changes no register, does not toggle the pointer, and leaves `rdata` at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select for the bank |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| port_ofs | input | 4 | Port offset within the bank |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| dreq | input | 4 | Per-channel request lines, shown in status |
| tc_pulse | input | 4 | Per-channel terminal-count pulses from the transfer engine |
| base_addr | output | 64 | Base address of channels 0..3, 16 bits each |
| base_count | output | 64 | Base count of channels 0..3, 16 bits each |
| chan_mode | output | 24 | Mode fields of channels 0..3, 6 bits each |
| chan_mask | output | 4 | Mask bit per channel, 1 = masked |
| cmd_reg | output | 8 | Command byte |

## Verification
Every result of this block lands exactly one clock after the strobe that causes it. This holds for the exported address, count, mode, mask and command values, for the mask set by a terminal-count pulse, and for the read byte. Status request bits trail `dreq` by one further stage. The bench drives inputs on the falling edge and compares every output with a behavioural model on the next falling edge. It adds directed checks at that same point, so each comparison falls exactly one rising edge after its stimulus. Stimuli that could collide at one edge are never driven together, with one exception: a terminal-count pulse arriving in a status-read cycle, which R9 defines.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
  localparam int unsigned CH_W   = 2;
  localparam int unsigned NUM_CH = 1 << CH_W;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned REG_W  = 2 * DATA_W;
  localparam int unsigned MODE_W = DATA_W - CH_W;
  localparam int unsigned OFS_W  = 4;
  // position of the auto-initialize flag inside the stored mode field
  localparam int unsigned AUTOINIT_BIT = 4 - CH_W;

  localparam logic [OFS_W-1:0] OFS_CMD_STAT  = 4'h8;
  localparam logic [OFS_W-1:0] OFS_MASK_ONE  = 4'hA;
  localparam logic [OFS_W-1:0] OFS_MODE      = 4'hB;
  localparam logic [OFS_W-1:0] OFS_PTR_CLR   = 4'hC;
  localparam logic [OFS_W-1:0] OFS_MCLR_TEMP = 4'hD;
  localparam logic [OFS_W-1:0] OFS_MASK_CLR  = 4'hE;
  localparam logic [OFS_W-1:0] OFS_MASK_ALL  = 4'hF;

  typedef struct packed {
    logic chan_wr;
    logic chan_rd;
    logic cmd_wr;
    logic stat_rd;
    logic mask_one;
    logic mode_wr;
    logic ptr_clr;
    logic mclr;
    logic mask_clr;
    logic mask_all;
  } strobe_t;
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regbank_pkg::*;
(
  input  logic             cs,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic [OFS_W-1:0] port_ofs,
  output strobe_t          stb
);
  logic do_wr, do_rd, chan_space;

  always_comb begin
    do_wr      = cs & wr_stb;
    do_rd      = cs & rd_stb;
    chan_space = ~port_ofs[OFS_W-1];
    stb.chan_wr  = do_wr & chan_space;
    stb.chan_rd  = do_rd & chan_space;
    stb.cmd_wr   = do_wr & (port_ofs == OFS_CMD_STAT);
    stb.stat_rd  = do_rd & (port_ofs == OFS_CMD_STAT);
    stb.mask_one = do_wr & (port_ofs == OFS_MASK_ONE);
    stb.mode_wr  = do_wr & (port_ofs == OFS_MODE);
    stb.ptr_clr  = do_wr & (port_ofs == OFS_PTR_CLR);
    stb.mclr     = do_wr & (port_ofs == OFS_MCLR_TEMP);
    stb.mask_clr = do_wr & (port_ofs == OFS_MASK_CLR);
    stb.mask_all = do_wr & (port_ofs == OFS_MASK_ALL);
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regbank_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned RW = REG_W,
  parameter int unsigned MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_hi,
  input  logic          addr_we,
  input  logic          cnt_we,
  input  logic          mode_we,
  input  logic [DW-1:0] wdata,
  output logic [RW-1:0] base_addr,
  output logic [RW-1:0] cur_addr,
  output logic [RW-1:0] base_cnt,
  output logic [RW-1:0] cur_cnt,
  output logic [MW-1:0] mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      cur_addr  <= '0;
      base_cnt  <= '0;
      cur_cnt   <= '0;
      mode      <= '0;
    end else begin
      if (addr_we) begin
        if (ptr_hi) begin
          base_addr[RW-1:DW] <= wdata;
          cur_addr[RW-1:DW]  <= wdata;
        end else begin
          base_addr[DW-1:0] <= wdata;
          cur_addr[DW-1:0]  <= wdata;
        end
      end
      if (cnt_we) begin
        if (ptr_hi) begin
          base_cnt[RW-1:DW] <= wdata;
          cur_cnt[RW-1:DW]  <= wdata;
        end else begin
          base_cnt[DW-1:0] <= wdata;
          cur_cnt[DW-1:0]  <= wdata;
        end
      end
      if (mode_we) mode <= wdata[DW-1:DW-MW];
    end
  end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_regbank_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH,
  parameter int unsigned CW  = CH_W,
  parameter int unsigned DW  = DATA_W
) (
  input  logic           clk,
  input  logic           rst,
  input  strobe_t        stb,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] tc_pulse,
  input  logic [NCH-1:0] autoinit,
  input  logic [NCH-1:0] dreq,
  output logic           ptr_hi,
  output logic [NCH-1:0] mask,
  output logic [DW-1:0]  cmd,
  output logic [NCH-1:0] tc_stat,
  output logic [NCH-1:0] dreq_q
);
  logic [NCH-1:0] mask_nxt;
  logic [NCH-1:0] tc_base;

  always_comb begin
    mask_nxt = mask;
    if (stb.mclr)          mask_nxt = '1;
    else if (stb.mask_clr) mask_nxt = '0;
    else if (stb.mask_all) mask_nxt = wdata[NCH-1:0];
    else if (stb.mask_one) mask_nxt[wdata[CW-1:0]] = wdata[CW];
    tc_base = (stb.stat_rd || stb.mclr) ? '0 : tc_stat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_hi  <= 1'b0;
      mask    <= '1;
      cmd     <= '0;
      tc_stat <= '0;
      dreq_q  <= '0;
    end else begin
      dreq_q <= dreq;
      if (stb.ptr_clr || stb.mclr)       ptr_hi <= 1'b0;
      else if (stb.chan_wr || stb.chan_rd) ptr_hi <= ~ptr_hi;
      if (stb.mclr)        cmd <= '0;
      else if (stb.cmd_wr) cmd <= wdata;
      tc_stat <= tc_base | tc_pulse;
      mask    <= mask_nxt | (tc_pulse & ~autoinit);
    end
  end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH,
  parameter int unsigned CW  = CH_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned RW  = REG_W,
  parameter int unsigned MW  = MODE_W,
  parameter int unsigned OW  = OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [OW-1:0]     port_ofs,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NCH-1:0]    dreq,
  input  logic [NCH-1:0]    tc_pulse,
  output logic [NCH*RW-1:0] base_addr,
  output logic [NCH*RW-1:0] base_count,
  output logic [NCH*MW-1:0] chan_mode,
  output logic [NCH-1:0]    chan_mask,
  output logic [DW-1:0]     cmd_reg
);
  strobe_t        stb;
  logic           ptr_hi;
  logic [NCH-1:0] tc_stat;
  logic [NCH-1:0] dreq_q;
  logic [NCH-1:0] autoinit;
  logic [RW-1:0]  cur_addr_a [NCH];
  logic [RW-1:0]  cur_cnt_a  [NCH];
  logic [CW-1:0]  sel_ch;
  logic [RW-1:0]  sel_word;
  logic [DW-1:0]  rd_mux;

  dma_port_decode u_dec (
    .cs(cs), .rd_stb(rd_stb), .wr_stb(wr_stb), .port_ofs(port_ofs), .stb(stb)
  );

  dma_ctrl_regs #(.NCH(NCH), .CW(CW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .stb(stb), .wdata(wdata), .tc_pulse(tc_pulse),
    .autoinit(autoinit), .dreq(dreq), .ptr_hi(ptr_hi), .mask(chan_mask),
    .cmd(cmd_reg), .tc_stat(tc_stat), .dreq_q(dreq_q)
  );

  assign sel_ch = port_ofs[CW:1];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic          addr_we, cnt_we, mode_we;
    logic [MW-1:0] mode_q;
    assign addr_we = stb.chan_wr && (sel_ch == CW'(ch)) && !port_ofs[0];
    assign cnt_we  = stb.chan_wr && (sel_ch == CW'(ch)) &&  port_ofs[0];
    assign mode_we = stb.mode_wr && (wdata[CW-1:0] == CW'(ch));
    dma_chan_regs #(.DW(DW), .RW(RW), .MW(MW)) u_chan (
      .clk(clk), .rst(rst), .ptr_hi(ptr_hi), .addr_we(addr_we),
      .cnt_we(cnt_we), .mode_we(mode_we), .wdata(wdata),
      .base_addr(base_addr[ch*RW +: RW]), .cur_addr(cur_addr_a[ch]),
      .base_cnt(base_count[ch*RW +: RW]), .cur_cnt(cur_cnt_a[ch]),
      .mode(mode_q)
    );
    assign chan_mode[ch*MW +: MW] = mode_q;
    assign autoinit[ch] = mode_q[AUTOINIT_BIT];
  end

  always_comb begin
    sel_word = port_ofs[0] ? cur_cnt_a[sel_ch] : cur_addr_a[sel_ch];
    rd_mux   = '0;
    if (stb.chan_rd)      rd_mux = ptr_hi ? sel_word[RW-1:DW] : sel_word[DW-1:0];
    else if (stb.stat_rd) rd_mux = {dreq_q, tc_stat};
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk (
  input logic        clk,
  input logic        rst,
  input logic        cs,
  input logic        rd_stb,
  input logic        wr_stb,
  input logic [3:0]  port_ofs,
  input logic [7:0]  wdata,
  input logic [3:0]  tc_pulse,
  input logic [23:0] chan_mode,
  input logic [3:0]  chan_mask,
  input logic [7:0]  cmd_reg,
  input logic [3:0]  tc_stat
);
  logic [3:0] no_reload;
  assign no_reload = {~chan_mode[20], ~chan_mode[14], ~chan_mode[8], ~chan_mode[2]};

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (chan_mask == 4'hF) && (cmd_reg == 8'h00)); // R1

  AST_MASK_ONE: assert property (@(posedge clk) disable iff (rst)
    (cs && wr_stb && port_ofs == 4'hA && tc_pulse == 4'h0)
    |=> chan_mask[$past(wdata[1:0])] == $past(wdata[2])); // R5

  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cs && wr_stb && port_ofs == 4'hE && tc_pulse == 4'h0) |=> chan_mask == 4'h0); // R7

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cs && rd_stb && port_ofs == 4'h8 && tc_pulse == 4'h0) |=> tc_stat == 4'h0); // R9

  AST_TC_MASKS: assert property (@(posedge clk) disable iff (rst)
    (tc_pulse != 4'h0) |=> ((chan_mask & $past(tc_pulse & no_reload)) == $past(tc_pulse & no_reload))); // R10

  AST_MASTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cs && wr_stb && port_ofs == 4'hD) |=> (chan_mask == 4'hF) && (cmd_reg == 8'h00) && (tc_stat == 4'h0 || $past(tc_pulse) != 4'h0)); // R11

  AST_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
    (!cs && tc_pulse == 4'h0) |=> $stable(chan_mask) && $stable(cmd_reg)); // R12
endmodule

bind dma_regbank dma_regbank_chk u_chk (
  .clk(clk), .rst(rst), .cs(cs), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .port_ofs(port_ofs), .wdata(wdata), .tc_pulse(tc_pulse),
  .chan_mode(chan_mode), .chan_mask(chan_mask), .cmd_reg(cmd_reg),
  .tc_stat(tc_stat)
);

// File: tb/dma_regbank_test.sv
module dma_regbank_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [3:0]  port_ofs = '0;
  logic [7:0]  wdata = '0;
  logic [3:0]  dreq = '0, tc_pulse = '0;
  logic [7:0]  rdata;
  logic [63:0] base_addr, base_count;
  logic [23:0] chan_mode;
  logic [3:0]  chan_mask;
  logic [7:0]  cmd_reg;

  dma_regbank uut (
    .clk(clk), .rst(rst), .cs(cs), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .port_ofs(port_ofs), .wdata(wdata), .rdata(rdata), .dreq(dreq),
    .tc_pulse(tc_pulse), .base_addr(base_addr), .base_count(base_count),
    .chan_mode(chan_mode), .chan_mask(chan_mask), .cmd_reg(cmd_reg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [15:0] m_a [4];
  logic [15:0] m_c [4];
  logic [5:0]  m_mode [4];
  logic [3:0]  m_mask, m_tc, m_dq;
  logic [7:0]  m_cmd, m_rd;
  bit          m_ff;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [7:0]  nrd;
    logic [3:0]  nmask, ntc;
    logic [15:0] v;
    cyc++;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_a[i] = 0; m_c[i] = 0; m_mode[i] = 0; end
      m_mask = 4'hF; m_tc = 0; m_dq = 0; m_cmd = 0; m_rd = 0; m_ff = 0;
    end else begin
      nrd = 0;
      if (cs && rd_stb) begin
        if (port_ofs < 4'h8) begin
          v = port_ofs[0] ? m_c[port_ofs[2:1]] : m_a[port_ofs[2:1]];
          nrd = m_ff ? v[15:8] : v[7:0];
        end else if (port_ofs == 4'h8) nrd = {m_dq, m_tc};
      end
      nmask = m_mask; ntc = m_tc;
      if (cs && rd_stb && port_ofs == 4'h8) ntc = 0;
      if (cs && wr_stb) begin
        if (port_ofs < 4'h8) begin
          if (port_ofs[0]) begin
            if (m_ff) m_c[port_ofs[2:1]][15:8] = wdata; else m_c[port_ofs[2:1]][7:0] = wdata;
          end else begin
            if (m_ff) m_a[port_ofs[2:1]][15:8] = wdata; else m_a[port_ofs[2:1]][7:0] = wdata;
          end
        end
        case (port_ofs)
          4'h8: m_cmd = wdata;
          4'hA: nmask[wdata[1:0]] = wdata[2];
          4'hB: m_mode[wdata[1:0]] = wdata[7:2];
          4'hD: begin m_cmd = 0; ntc = 0; nmask = 4'hF; end
          4'hE: nmask = 4'h0;
          4'hF: nmask = wdata[3:0];
          default: ;
        endcase
      end
      if (cs && (rd_stb || wr_stb) && port_ofs < 4'h8) m_ff = !m_ff;
      if (cs && wr_stb && (port_ofs == 4'hC || port_ofs == 4'hD)) m_ff = 0;
      for (int i = 0; i < 4; i++)
        if (tc_pulse[i]) begin
          ntc[i] = 1'b1;
          if (!m_mode[i][2]) nmask[i] = 1'b1;
        end
      m_mask = nmask; m_tc = ntc; m_dq = dreq; m_rd = nrd;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      chk(chan_mask == m_mask, "R5 mask vs model", chan_mask, m_mask);
      chk(cmd_reg == m_cmd, "R8 command vs model", cmd_reg, m_cmd);
      chk(rdata == m_rd, "R3 rdata vs model", rdata, m_rd);
      for (int i = 0; i < 4; i++) begin
        chk(base_addr[16*i +: 16] == m_a[i], "R2 base address vs model", base_addr[16*i +: 16], m_a[i]);
        chk(base_count[16*i +: 16] == m_c[i], "R2 base count vs model", base_count[16*i +: 16], m_c[i]);
        chk(chan_mode[6*i +: 6] == m_mode[i], "R6 mode vs model", chan_mode[6*i +: 6], m_mode[i]);
      end
    end
  end

  task automatic wr(input logic [3:0] o, input logic [7:0] d);
    cs = 1; wr_stb = 1; port_ofs = o; wdata = d;
    @(negedge clk);
    cs = 0; wr_stb = 0;
  endtask

  task automatic rd(input logic [3:0] o, input logic [7:0] exp, input string tag);
    cs = 1; rd_stb = 1; port_ofs = o;
    @(negedge clk);
    cs = 0; rd_stb = 0;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic pulse(input logic [3:0] t);
    tc_pulse = t;
    @(negedge clk);
    tc_pulse = 0;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(rdata == 8'h00, "R1 rdata after reset", rdata, 8'h00);
    chk(chan_mask == 4'hF, "R1 mask after reset", chan_mask, 4'hF);
    chk(cmd_reg == 8'h00, "R1 command after reset", cmd_reg, 8'h00);
    chk(base_addr == 64'h0, "R1 addresses after reset", base_addr, 64'h0);

    wr(4'hC, 8'h5A);
    wr(4'h2, 8'h34); wr(4'h2, 8'h12);
    wr(4'h3, 8'hFF); wr(4'h3, 8'h0F);
    chk(base_addr[31:16] == 16'h1234, "R2 ch1 address", base_addr[31:16], 16'h1234);
    chk(base_count[31:16] == 16'h0FFF, "R2 ch1 count", base_count[31:16], 16'h0FFF);
    rd(4'h2, 8'h34, "R3 ch1 address low");
    rd(4'h2, 8'h12, "R3 ch1 address high");

    wr(4'h4, 8'hAA);
    rd(4'h3, 8'h0F, "R4 pointer shared across channels");
    wr(4'h4, 8'hCC);
    wr(4'hC, 8'h5A);
    rd(4'h3, 8'hFF, "R4 pointer cleared by 0xC");
    rd(4'h3, 8'h0F, "R4 pointer toggles after clear");
    chk(base_addr[47:32] == 16'h00CC, "R4 ch2 low byte overwritten", base_addr[47:32], 16'h00CC);

    wr(4'hB, 8'h46);
    chk(chan_mode[17:12] == 6'h11, "R6 ch2 mode 0x46", chan_mode[17:12], 6'h11);
    wr(4'hB, 8'h49);
    chk(chan_mode[11:6] == 6'h12, "R6 ch1 mode 0x49", chan_mode[11:6], 6'h12);
    wr(4'hB, 8'hC3);
    chk(chan_mode[23:18] == 6'h30, "R6 ch3 cascade mode", chan_mode[23:18], 6'h30);
    wr(4'hB, 8'h54);
    chk(chan_mode[5:0] == 6'h15, "R6 ch0 autoinit mode", chan_mode[5:0], 6'h15);

    wr(4'hE, 8'h00);
    chk(chan_mask == 4'h0, "R7 clear all masks", chan_mask, 4'h0);
    wr(4'hA, 8'h06);
    chk(chan_mask == 4'h4, "R5 mask ch2", chan_mask, 4'h4);
    wr(4'hA, 8'h0A);
    chk(chan_mask == 4'h0, "R5 unmask ch2", chan_mask, 4'h0);
    wr(4'hA, 8'h05);
    chk(chan_mask == 4'h2, "R5 mask ch1", chan_mask, 4'h2);
    wr(4'hF, 8'hF9);
    chk(chan_mask == 4'h9, "R7 write all masks", chan_mask, 4'h9);
    wr(4'hE, 8'hFF);

    wr(4'h8, 8'hA5);
    chk(cmd_reg == 8'hA5, "R8 command write", cmd_reg, 8'hA5);

    dreq = 4'b1010;
    @(negedge clk);
    pulse(4'b0010);
    chk(chan_mask == 4'h2, "R10 tc masks non-autoinit ch1", chan_mask, 4'h2);
    pulse(4'b0001);
    chk(chan_mask == 4'h2, "R10 tc leaves autoinit ch0 unmasked", chan_mask, 4'h2);
    rd(4'h8, 8'hA3, "R9 status with tc flags");
    tc_pulse = 4'b1000;
    rd(4'h8, 8'hA0, "R9 status cleared by read");
    tc_pulse = 0;
    rd(4'h8, 8'hA8, "R9 tc during read survives");
    rd(4'h8, 8'hA0, "R9 status clear again");

    wr(4'h8, 8'h5C);
    wr(4'h2, 8'h77);
    pulse(4'b0100);
    wr(4'hD, 8'h00);
    chk(chan_mask == 4'hF, "R11 master clear masks", chan_mask, 4'hF);
    chk(cmd_reg == 8'h00, "R11 master clear command", cmd_reg, 8'h00);
    rd(4'h8, 8'hA0, "R11 master clear status");
    rd(4'h2, 8'h77, "R11 pointer low and address kept");
    rd(4'h2, 8'h12, "R11 address high kept");
    rd(4'hD, 8'h00, "R11 temporary read");

    wr_stb = 1; port_ofs = 4'hE; wdata = 8'h00;
    @(negedge clk);
    port_ofs = 4'h8; wdata = 8'hFF;
    @(negedge clk);
    port_ofs = 4'h2; wdata = 8'h99;
    @(negedge clk);
    wr_stb = 0;
    chk(chan_mask == 4'hF, "R12 mask untouched without select", chan_mask, 4'hF);
    chk(cmd_reg == 8'h00, "R12 command untouched without select", cmd_reg, 8'h00);
    rd(4'h2, 8'h77, "R12 address and pointer untouched");
    rd_stb = 1; port_ofs = 4'h2;
    @(negedge clk);
    rd_stb = 0;
    chk(rdata == 8'h00, "R12 unselected read gives zero", rdata, 8'h00);
    rd(4'h2, 8'h12, "R12 pointer not toggled by unselected read");

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule